// File: doc/BRIEF.md
# Moving-Sum Window over a RAM Delay Line

This block keeps a running total of the most recent 50 samples of an unsigned sample stream, and also gives that total divided by the window length. It does not add up the whole window on every sample. It holds one rolling sum. Each accepted sample is added to that sum, and the sample that arrived one window earlier is taken away.

The samples still inside the window sit in a small inferred single-clock memory. A wrapping pointer addresses that memory. The design uses no chain of shift registers, so the window storage needs no flip-flops. The pointer selects the oldest entry, the memory reads it, and in the same write slot the new sample replaces it. Until one full window has arrived, the entries that have not been written yet count as zero. A fill counter gives this behaviour, so the memory needs no clearing at reset.

Input and output are both qualified by a valid strobe. Each accepted sample produces exactly one output beat. The input may be valid on every cycle or only on some cycles.

Top module: `moving_sum_window`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `out_valid` is 0 and `out_sum` and `out_avg` are 0. A reset also empties the window.
- R2: Each cycle with `in_valid` high produces exactly one cycle with `out_valid` high, two clock cycles later. No other cycle raises `out_valid`.
- R3: On an output beat, `out_sum` equals the sum of the last min(n, 50) accepted samples, where n is the number of samples accepted since reset. Window positions that have not been filled yet count as zero.
- R4: Cycles with `in_valid` low change neither the window contents nor `out_sum`. Between beats, `out_sum` holds its last value.
- R5: `out_avg` equals floor(`out_sum` / 50), computed with a constant multiply and a right shift. It is exact for every reachable sum.
- R6: The window stays correct after the memory pointer has wrapped many times, that is, after more than 100 samples.
- R7: `out_sum` is DATA_W+6 bits wide. A full window of maximum-value samples (50 × 4095 = 204750 at the default width) gives the exact result without overflow.
- R8: Samples arriving on consecutive cycles (back-to-back) and samples separated by idle gaps of any length give the same results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe |
| in_data | input | DATA_W (12) | Unsigned sample |
| out_valid | output | 1 | Result strobe, two cycles after the sample |
| out_sum | output | DATA_W+6 (18) | Sum of the current window |
| out_avg | output | DATA_W (12) | Window sum divided by 50, rounded down |

## Verification
The assertions check these properties on every cycle:
- the pointer stays within the window range;
- the fill count saturates;
- the pointer and fill state hold steady on idle cycles;
- the sum never exceeds a full window of maximum samples;
- the sum is zero before any sample has arrived;
- the average and the sum agree by division.

None of these can show that the value subtracted is the right one, or that it comes from the right position in the window. Only the bench's scenarios can show that. The bench tracks a 50-entry reference queue through several data patterns: random values, full-scale values, zeros and ramps. It runs them back-to-back, with fixed gaps and with random gaps, and across a reset in the middle of the run. At each output beat it checks the latency, the sum and the average against that queue.

// File: rtl/moving_sum_window.sv
module moving_sum_window #(
  parameter int DATA_W = 12,
  parameter int WIN    = 50
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              in_valid,
  input  logic [DATA_W-1:0]                 in_data,
  output logic                              out_valid,
  output logic [DATA_W+$clog2(WIN)-1:0]     out_sum,
  output logic [DATA_W-1:0]                 out_avg
);
  localparam int PTR_W  = $clog2(WIN);
  localparam int CNT_W  = $clog2(WIN + 1);
  localparam int SUM_W  = DATA_W + $clog2(WIN);
  localparam int SHIFT  = SUM_W + $clog2(WIN);
  localparam int PROD_W = SUM_W + SHIFT;
  localparam longint unsigned MULT    = ((64'd1 << SHIFT) + WIN - 1) / WIN;
  localparam longint unsigned SUM_MAX = longint'(WIN) * ((64'd1 << DATA_W) - 1);

  logic [DATA_W-1:0] mem [WIN];
  logic [DATA_W-1:0] rd_q;
  logic [PTR_W-1:0]  ptr;
  logic [CNT_W-1:0]  fill;
  logic              s1_valid, s1_old_ok;
  logic [DATA_W-1:0] s1_data;
  logic [SUM_W-1:0]  sum_q;

  // read-before-write on the same address: rd_q receives the oldest sample
  always_ff @(posedge clk) begin
    if (in_valid) begin
      rd_q     <= mem[ptr];
      mem[ptr] <= in_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr       <= '0;
      fill      <= '0;
      s1_valid  <= 1'b0;
      s1_old_ok <= 1'b0;
      s1_data   <= '0;
      sum_q     <= '0;
      out_valid <= 1'b0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        ptr       <= (ptr == PTR_W'(WIN - 1)) ? '0 : ptr + 1'b1;
        fill      <= (fill == CNT_W'(WIN)) ? fill : fill + 1'b1;
        s1_old_ok <= (fill == CNT_W'(WIN));
        s1_data   <= in_data;
      end
      if (s1_valid)
        sum_q <= sum_q + SUM_W'(s1_data) - (s1_old_ok ? SUM_W'(rd_q) : '0);
      out_valid <= s1_valid;
    end
  end

  assign out_sum = sum_q;
  assign out_avg = DATA_W'((PROD_W'(sum_q) * PROD_W'(MULT)) >> SHIFT);

  a_r6_ptr_range: assert property (@(posedge clk) disable iff (rst)
    int'(ptr) < WIN);
  a_r3_fill_sat: assert property (@(posedge clk) disable iff (rst)
    int'(fill) <= WIN);
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(ptr) && $stable(fill));
  a_r7_sum_bound: assert property (@(posedge clk) disable iff (rst)
    longint'(sum_q) <= SUM_MAX);
  a_r3_empty_zero: assert property (@(posedge clk) disable iff (rst)
    (fill == '0) |-> (sum_q == '0));

  always_comb begin
    if (!rst && out_valid)
      a_r5_avg_div: assert (longint'(out_avg) * WIN <= longint'(out_sum) &&
                            longint'(out_sum) < (longint'(out_avg) + 1) * WIN);
  end
endmodule

// File: tb/moving_sum_window_bench.sv
`timescale 1ns/1ps
module moving_sum_window_bench;
  localparam int DATA_W = 12;
  localparam int WIN    = 50;
  localparam int SUM_W  = DATA_W + 6;
  localparam int PAT_N  = 8;
  // {sample count, data mode, gap}; mode 0 random, 1 full scale, 2 zero, 3 ramp; gap 99 = random 0..3
  localparam int unsigned PAT [PAT_N][3] = '{
    '{55, 1, 0},   // R7 full-scale window, R8 back-to-back
    '{40, 2, 0},   // R3 draining with zeros
    '{120, 0, 0},  // R6 pointer wraps, R8
    '{70, 0, 3},   // R4 fixed gaps
    '{60, 3, 1},   // ramp with single idle cycles
    '{80, 0, 99},  // R8 random gaps
    '{50, 1, 2},   // R7 full scale with gaps
    '{30, 0, 0}
  };

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic out_valid;
  logic [SUM_W-1:0] out_sum;
  logic [DATA_W-1:0] out_avg;

  moving_sum_window #(.DATA_W(DATA_W), .WIN(WIN)) u_moving_sum_window (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_sum(out_sum), .out_avg(out_avg));

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  int unsigned win_q[$];
  int unsigned exp_sum_q[$];
  int exp_cyc_q[$];
  int unsigned ref_sum = 0, last_sum = 0, e_sum = 0;
  int e_cyc = 0;
  bit have_last = 0, mon_en = 0;
  bit [31:0] rng = 32'h1bad_5eed;

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit [31:0] next_rng(bit [31:0] x);
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic send(int unsigned d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d[DATA_W-1:0];
    win_q.push_back(d);
    ref_sum += d;
    if (win_q.size() > WIN) ref_sum -= win_q.pop_front();
    exp_sum_q.push_back(ref_sum);
    exp_cyc_q.push_back(cyc + 2);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      if (out_valid) begin
        if (exp_sum_q.size() == 0) begin
          check(1'b0, "R2 unexpected out_valid", 1, 0);
        end else begin
          e_sum = exp_sum_q.pop_front();
          e_cyc = exp_cyc_q.pop_front();
          check(cyc == e_cyc, "R2 latency", cyc, e_cyc);
          check(out_sum == SUM_W'(e_sum), "R3 window sum", out_sum, e_sum);
          check(out_avg == DATA_W'(e_sum / WIN), "R5 average", out_avg, e_sum / WIN);
          last_sum  = e_sum;
          have_last = 1;
        end
      end else if (have_last) begin
        check(out_sum == SUM_W'(last_sum), "R4 idle hold", out_sum, last_sum);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R2 watchdog", 0, 1);
    summary();
  end

  initial begin
    int unsigned d;
    int gap;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 reset valid", out_valid, 0);
    check(out_sum == '0, "R1 reset sum", out_sum, 0);
    @(negedge clk);
    rst = 1'b0;
    check(out_valid == 1'b0 && out_sum == '0 && out_avg == '0, "R1 after release", out_sum, 0);
    mon_en = 1;

    for (int p = 0; p < PAT_N; p++) begin
      for (int i = 0; i < int'(PAT[p][0]); i++) begin
        rng = next_rng(rng);
        case (PAT[p][1])
          0: d = rng[DATA_W-1:0];
          1: d = (1 << DATA_W) - 1;
          2: d = 0;
          default: d = (i * 37) % (1 << DATA_W);
        endcase
        send(d);
        gap = (PAT[p][2] == 99) ? int'(rng[13:12]) : int'(PAT[p][2]);
        if (gap > 0) idle(gap);
      end
      idle(1);
    end
    idle(5);
    check(exp_sum_q.size() == 0, "R2 all beats seen", exp_sum_q.size(), 0);

    // R1: reset in the middle of the run empties the window
    mon_en = 0;
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0 && out_sum == '0 && out_avg == '0, "R1 mid-run reset", out_sum, 0);
    win_q.delete(); ref_sum = 0; have_last = 0;
    rst = 1'b0;
    @(negedge clk);
    mon_en = 1;
    // R3: after the reset the stale memory must count as zero
    for (int i = 0; i < 60; i++) begin
      rng = next_rng(rng);
      send(rng[DATA_W-1:0]);
      if (i % 7 == 3) idle(2);
    end
    idle(6);
    check(exp_sum_q.size() == 0, "R2 all beats seen after reset", exp_sum_q.size(), 0);
    summary();
  end
endmodule